// File: doc/BRIEF.md
# Channel Measurement Capture Unit

This unit freezes the measurement state of a group of correlator channels at each timing pulse. On a pulse, each channel copies four live values (code phase, the 1 ms and 20 ms epoch counts, and the carrier cycle count) into holding registers. It then raises that channel's new-data bit. The pulse raises no interrupt. Software polls a status word, reads the channel's holding registers and finishes with the carrier-cycle register.

Reading the carrier-cycle register lifts the channel's overwrite guard. While the guard is up, later pulses leave the holding registers alone and set a sticky missed-capture flag instead. A second status word carries that flag and a flag showing that the code or epoch counters were being slewed during the period that ended in the accepted capture. Software can also drop a channel's status without reading any data, by writing the channel's clear address.

The register bus is a single-cycle port. Read data is combinational from the address while `rd_en` is high. Any state change from a read or write takes effect at the clock edge that ends that cycle. Address bit [AW-1] selects the global status words. Otherwise bits [AW-2:2] select the channel and bits [1:0] select the register.

Top module: `meas_snapshot`

## Requirements
- R1: A synchronous active-high reset clears every new-data, missed and slewed bit and every holding register. Every status and data read then returns 0.
- R2: A pulse on `tic` in a cycle where a channel is unguarded does two things at the end of that cycle. It loads the channel's phase, epochs and carrier count from the live inputs, and it sets the channel's new-data bit, which is bit i of the new-data status word (global register 0).
- R3: A pulse on `tic` while a channel's new-data bit is set and no clear arrives in that cycle leaves all holding registers unchanged. It also sets the channel's missed flag, which is bit i of the flags word (global register 1). The flag stays set across further pulses.
- R4: A read of channel register 2 (carrier count) clears the channel's new-data, missed and slewed bits at the end of the read cycle. It returns the value held before that edge.
- R5: A write to channel register 3 clears the same three bits without changing any holding register.
- R6: If `slew_act[i]` is high in any cycle of a pulse period, including the pulse cycle itself, the next accepted capture sets bit NCH+i of the flags word. The accumulation restarts at every pulse.
- R7: Reads of channel registers 0 (phase) and 1 (epochs) change no status bit.
- R8: Channel register 1 returns the 20 ms count in bits [E1_W+E20_W-1:E1_W] and the 1 ms count in bits [E1_W-1:0]. Registers 0 and 2 return their value zero-extended.
- R9: When a clear (R4 or R5) and a pulse fall in the same cycle, the capture is accepted and the missed flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tic | input | 1 | Capture pulse, one cycle wide |
| slew_act | input | NCH | Per-channel slew in progress |
| live_phase | input | NCH*PH_W | Live code phase, channel i at [i*PH_W +: PH_W] |
| live_ep1 | input | NCH*E1_W | Live 1 ms epoch counts |
| live_ep20 | input | NCH*E20_W | Live 20 ms epoch counts |
| live_carr | input | NCH*CC_W | Live carrier cycle counts |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (only clear addresses respond) |
| addr | input | AW | Register address |
| rd_data | output | DW | Read data, valid while rd_en is high |

## Verification
A stuck guard bit shows up at the first pulse after a carrier read. The new-data word stays set and the missed flag rises when the holding value should have changed. An early release shows up as fresh data overwriting a value that was never read, visible at the next carrier read. A slew accumulator that fails to restart shows up as a spurious slewed bit one period later. Each of these appears on `rd_data` within two bus cycles of the pulse that exposes it.

// File: rtl/snap_pkg.sv
package snap_pkg;
    typedef enum logic [1:0] {
        CREG_PHASE = 2'd0,
        CREG_EPOCH = 2'd1,
        CREG_CARR  = 2'd2,
        CREG_CLR   = 2'd3
    } chan_reg_e;

    typedef enum logic [1:0] {
        GREG_NEW   = 2'd0,
        GREG_FLAGS = 2'd1,
        GREG_RSV2  = 2'd2,
        GREG_RSV3  = 2'd3
    } glob_reg_e;
endpackage

// File: rtl/snap_chan.sv
module snap_chan #(
    parameter int PH_W  = 20,
    parameter int E1_W  = 5,
    parameter int E20_W = 10,
    parameter int CC_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tic,
    input  logic             slew_act,
    input  logic             clr,
    input  logic [PH_W-1:0]  live_phase,
    input  logic [E1_W-1:0]  live_ep1,
    input  logic [E20_W-1:0] live_ep20,
    input  logic [CC_W-1:0]  live_carr,
    output logic [PH_W-1:0]  hold_phase,
    output logic [E1_W-1:0]  hold_ep1,
    output logic [E20_W-1:0] hold_ep20,
    output logic [CC_W-1:0]  hold_carr,
    output logic             fresh,
    output logic             missed,
    output logic             slewed
);
    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [E1_W-1:0]  ep1;
        logic [E20_W-1:0] ep20;
        logic [CC_W-1:0]  carr;
        logic             fresh;
        logic             missed;
        logic             slewed;
        logic             slew_acc;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     guarded;

    always_comb begin
        st_d    = st_q;
        guarded = st_q.fresh & ~clr;
        if (clr) begin
            st_d.fresh  = 1'b0;
            st_d.missed = 1'b0;
            st_d.slewed = 1'b0;
        end
        if (tic) begin
            st_d.slew_acc = 1'b0;
            if (guarded) begin
                st_d.missed = 1'b1;
            end else begin
                st_d.phase  = live_phase;
                st_d.ep1    = live_ep1;
                st_d.ep20   = live_ep20;
                st_d.carr   = live_carr;
                st_d.fresh  = 1'b1;
                st_d.slewed = st_q.slew_acc | slew_act;
            end
        end else begin
            st_d.slew_acc = st_q.slew_acc | slew_act;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hold_phase = st_q.phase;
    assign hold_ep1   = st_q.ep1;
    assign hold_ep20  = st_q.ep20;
    assign hold_carr  = st_q.carr;
    assign fresh      = st_q.fresh;
    assign missed     = st_q.missed;
    assign slewed     = st_q.slewed;
endmodule

// File: rtl/snap_decode.sv
module snap_decode
    import snap_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int PH_W  = 20,
    parameter int E1_W  = 5,
    parameter int E20_W = 10,
    parameter int CC_W  = 20,
    parameter int DW    = 32,
    parameter int CHW   = 1,
    parameter int AW    = 4
) (
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [NCH*PH_W-1:0]  hold_phase,
    input  logic [NCH*E1_W-1:0]  hold_ep1,
    input  logic [NCH*E20_W-1:0] hold_ep20,
    input  logic [NCH*CC_W-1:0]  hold_carr,
    input  logic [NCH-1:0]       fresh,
    input  logic [NCH-1:0]       missed,
    input  logic [NCH-1:0]       slewed,
    output logic [NCH-1:0]       clr,
    output logic [DW-1:0]        rd_data
);
    logic            is_glob;
    logic [CHW-1:0]  ch_sel;
    chan_reg_e       creg;
    glob_reg_e       greg;

    assign is_glob = addr[AW-1];
    assign ch_sel  = addr[AW-2:2];
    assign creg    = chan_reg_e'(addr[1:0]);
    assign greg    = glob_reg_e'(addr[1:0]);

    always_comb begin
        clr     = '0;
        rd_data = '0;
        if (is_glob) begin
            if (rd_en && greg == GREG_NEW) begin
                rd_data[NCH-1:0] = fresh;
            end else if (rd_en && greg == GREG_FLAGS) begin
                rd_data[2*NCH-1:0] = {slewed, missed};
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_sel == CHW'(i)) begin
                    clr[i] = (rd_en && creg == CREG_CARR) ||
                             (wr_en && creg == CREG_CLR);
                    if (rd_en) begin
                        case (creg)
                            CREG_PHASE: rd_data[PH_W-1:0] = hold_phase[i*PH_W +: PH_W];
                            CREG_EPOCH: rd_data[E1_W+E20_W-1:0] =
                                {hold_ep20[i*E20_W +: E20_W], hold_ep1[i*E1_W +: E1_W]};
                            CREG_CARR:  rd_data[CC_W-1:0] = hold_carr[i*CC_W +: CC_W];
                            default:    rd_data = '0;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/meas_snapshot.sv
module meas_snapshot #(
    parameter int NCH   = 2,
    parameter int PH_W  = 20,
    parameter int E1_W  = 5,
    parameter int E20_W = 10,
    parameter int CC_W  = 20,
    parameter int DW    = 32,
    parameter int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int AW    = CHW + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tic,
    input  logic [NCH-1:0]       slew_act,
    input  logic [NCH*PH_W-1:0]  live_phase,
    input  logic [NCH*E1_W-1:0]  live_ep1,
    input  logic [NCH*E20_W-1:0] live_ep20,
    input  logic [NCH*CC_W-1:0]  live_carr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    output logic [DW-1:0]        rd_data
);
    logic [NCH*PH_W-1:0]  hold_phase_w;
    logic [NCH*E1_W-1:0]  hold_ep1_w;
    logic [NCH*E20_W-1:0] hold_ep20_w;
    logic [NCH*CC_W-1:0]  hold_carr_w;
    logic [NCH-1:0]       fresh_w, missed_w, slewed_w, clr_w;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        snap_chan #(
            .PH_W(PH_W), .E1_W(E1_W), .E20_W(E20_W), .CC_W(CC_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .tic        (tic),
            .slew_act   (slew_act[g]),
            .clr        (clr_w[g]),
            .live_phase (live_phase[g*PH_W +: PH_W]),
            .live_ep1   (live_ep1[g*E1_W +: E1_W]),
            .live_ep20  (live_ep20[g*E20_W +: E20_W]),
            .live_carr  (live_carr[g*CC_W +: CC_W]),
            .hold_phase (hold_phase_w[g*PH_W +: PH_W]),
            .hold_ep1   (hold_ep1_w[g*E1_W +: E1_W]),
            .hold_ep20  (hold_ep20_w[g*E20_W +: E20_W]),
            .hold_carr  (hold_carr_w[g*CC_W +: CC_W]),
            .fresh      (fresh_w[g]),
            .missed     (missed_w[g]),
            .slewed     (slewed_w[g])
        );
    end

    snap_decode #(
        .NCH(NCH), .PH_W(PH_W), .E1_W(E1_W), .E20_W(E20_W), .CC_W(CC_W),
        .DW(DW), .CHW(CHW), .AW(AW)
    ) u_dec (
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .hold_phase (hold_phase_w),
        .hold_ep1   (hold_ep1_w),
        .hold_ep20  (hold_ep20_w),
        .hold_carr  (hold_carr_w),
        .fresh      (fresh_w),
        .missed     (missed_w),
        .slewed     (slewed_w),
        .clr        (clr_w),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/snap_chk.sv
module snap_chk #(
    parameter int NCH  = 2,
    parameter int CC_W = 20
) (
    input logic                clk,
    input logic                rst,
    input logic                tic,
    input logic [NCH-1:0]      slew_act,
    input logic [NCH-1:0]      clr,
    input logic [NCH-1:0]      fresh,
    input logic [NCH-1:0]      missed,
    input logic [NCH-1:0]      slewed,
    input logic [NCH*CC_W-1:0] hold_carr,
    input logic [NCH*CC_W-1:0] live_carr
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (fresh == '0 && missed == '0 && slewed == '0 && hold_carr == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
            (tic && !fresh[i]) |=>
                (fresh[i] && hold_carr[i*CC_W +: CC_W] == $past(live_carr[i*CC_W +: CC_W])));

        assert_guard_R3: assert property (@(posedge clk) disable iff (rst)
            (tic && fresh[i] && !clr[i]) |=>
                ($stable(hold_carr[i*CC_W +: CC_W]) && missed[i]));

        assert_release_R4: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !tic) |=> (!fresh[i] && !missed[i] && !slewed[i]));

        assert_slew_R6: assert property (@(posedge clk) disable iff (rst)
            (tic && slew_act[i] && (!fresh[i] || clr[i])) |=> slewed[i]);

        assert_coincide_R9: assert property (@(posedge clk) disable iff (rst)
            (tic && clr[i]) |=> (fresh[i] && !missed[i]));
    end
endmodule

bind meas_snapshot snap_chk #(.NCH(NCH), .CC_W(CC_W)) u_snap_chk (
    .clk       (clk),
    .rst       (rst),
    .tic       (tic),
    .slew_act  (slew_act),
    .clr       (clr_w),
    .fresh     (fresh_w),
    .missed    (missed_w),
    .slewed    (slewed_w),
    .hold_carr (hold_carr_w),
    .live_carr (live_carr)
);

// File: tb/tb_meas_snapshot.sv
module tb_meas_snapshot;
    localparam int NCH = 2, PH_W = 20, E1_W = 5, E20_W = 10, CC_W = 20, DW = 32, AW = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tic = 1'b0;
    logic [NCH-1:0]       slew_act = '0;
    logic [NCH*PH_W-1:0]  live_phase = '0;
    logic [NCH*E1_W-1:0]  live_ep1 = '0;
    logic [NCH*E20_W-1:0] live_ep20 = '0;
    logic [NCH*CC_W-1:0]  live_carr = '0;
    logic                 rd_en = 1'b0;
    logic                 wr_en = 1'b0;
    logic [AW-1:0]        addr = '0;
    logic [DW-1:0]        rd_data;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] exp_q[$];
    string         req_q[$];

    always #4 clk = ~clk;

    meas_snapshot dut (
        .clk(clk), .rst(rst), .tic(tic), .slew_act(slew_act),
        .live_phase(live_phase), .live_ep1(live_ep1), .live_ep20(live_ep20),
        .live_carr(live_carr), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .rd_data(rd_data)
    );

    function automatic logic [AW-1:0] ca(input int ch, input int r);
        return {1'b0, 1'(ch), 2'(r)};
    endfunction
    localparam logic [AW-1:0] A_NEW = 4'b1000, A_FLAGS = 4'b1001;

    // monitor: compare every read against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_en) begin
            logic [DW-1:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            total++;
            if (rd_data !== e) begin
                bad++;
                $display("FAIL %s addr=%b actual=%h expected=%h", r, addr, rd_data, e);
            end
        end
    end

    // driver: one bus cycle, optional pulse
    task automatic op(input logic w, input logic r, input logic [AW-1:0] a,
                      input logic t, input logic [DW-1:0] e, input string req);
        wr_en = w; rd_en = r; addr = a; tic = t;
        if (r) begin exp_q.push_back(e); req_q.push_back(req); end
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; addr = '0; tic = 0;
    endtask
    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
        op(1'b0, 1'b1, a, 1'b0, e, req);
    endtask
    task automatic pulse();
        op(1'b0, 1'b0, '0, 1'b1, '0, "");
    endtask
    task automatic clr(input int ch);
        op(1'b1, 1'b0, ca(ch, 3), 1'b0, '0, "");
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) op(1'b0, 1'b0, '0, 1'b0, '0, "");
    endtask

    logic done = 1'b0;
    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        rd(A_NEW, 0, "R1");
        rd(A_FLAGS, 0, "R1");
        rd(ca(0, 2), 0, "R1");

        live_phase = {20'h00FF0, 20'h12345};
        live_ep1   = {5'd19, 5'd7};
        live_ep20  = {10'd999, 10'd300};
        live_carr  = {20'h54321, 20'hABCDE};
        pulse();
        rd(A_NEW, 3, "R2");
        rd(ca(0, 0), 32'h12345, "R2");
        rd(ca(0, 1), (300 << 5) | 7, "R8");
        rd(ca(1, 1), (999 << 5) | 19, "R8");
        rd(A_NEW, 3, "R7");
        rd(ca(0, 2), 32'hABCDE, "R4");
        rd(A_NEW, 2, "R4");

        // ch1 guarded, ch0 free
        live_phase = {20'h0AAAA, 20'h0BBBB};
        live_carr  = {20'h22222, 20'h11111};
        pulse();
        rd(A_NEW, 3, "R2");
        rd(A_FLAGS, 2, "R3");
        rd(ca(1, 0), 32'h00FF0, "R3");
        rd(ca(1, 2), 32'h54321, "R3");
        rd(A_FLAGS, 0, "R4");
        rd(A_NEW, 1, "R4");

        // R5 write clear
        clr(0);
        rd(A_NEW, 0, "R5");
        rd(ca(0, 0), 32'h0BBBB, "R5");

        // R6 slew accumulation
        slew_act = 2'b01; idle(3);
        slew_act = 2'b00; idle(2);
        pulse();
        rd(A_FLAGS, 4, "R6");
        rd(A_NEW, 3, "R6");
        clr(0); clr(1);
        rd(A_FLAGS, 0, "R5");
        pulse();
        rd(A_FLAGS, 0, "R6");

        // R9 clear coinciding with pulse on ch0; ch1 still guarded
        live_carr = {20'h44444, 20'h33333};
        op(1'b0, 1'b1, ca(0, 2), 1'b1, 32'h11111, "R9");
        rd(A_NEW, 3, "R9");
        rd(A_FLAGS, 2, "R9");
        rd(ca(0, 2), 32'h33333, "R9");
        rd(ca(1, 2), 32'h22222, "R3");

        // R1 reset mid-run
        pulse();
        rst = 1; idle(2); rst = 0;
        rd(A_NEW, 0, "R1");
        rd(A_FLAGS, 0, "R1");
        rd(ca(1, 0), 0, "R1");

        idle(2);
        if (exp_q.size() != 0) begin
            bad++; total++;
            $display("FAIL scoreboard left %0d items", exp_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule